// File: doc/BRIEF.md
# Off-Hook Line Intrusion Detector

This block supervises a telephone line interface while it is off-hook and decides when another device on the same pair has picked up. It reads a 5-bit loop-current sense value once per sample period, keeps a reference level that follows the settled line current, and flags an intrusion when the current falls clearly below that reference on two samples in a row. The flag is sticky until the host clears it. It can drive a maskable interrupt and, when enabled, a one-cycle hang-up request.

Timing comes from a 1 ms tick input. After each transition to off-hook the block waits a programmable settling time in 100 ms units. It then samples every `cfg_period` × 40 ms. A dial-start pulse opens a blocking window of 0, 1, 2 or 4 seconds. Samples that arrive inside the window are thrown away. The reference level and the detect flag survive an on-hook period. Every other piece of state restarts when the line goes on-hook.

Top module: `line_intrusion_det`

## Requirements
- R1: After reset `detect`, `irq`, `line_in_use` and `hangup_req` are 0 and `ref_level` is 0.
- R2: After the line goes off-hook, the first sample is taken `cfg_settle` × 100 ticks later (at least 1 tick). Later samples follow every `cfg_period` × 40 ticks, and a period code of 0 acts as 1.
- R3: On a sample whose value equals the previous sample, where the signed difference `ref_level` − sample is less than `cfg_thresh`, `ref_level` takes the sample. This update is skipped while `cfg_force` is 1 or `detect` is 1. A host write (`ref_wr`) always loads `ref_wr_data`.
- R4: If `ref_level` is 0 when the line goes off-hook, no comparison is made until two samples have been taken.
- R5: `detect` is set when `ref_level` − previous sample and `ref_level` − current sample are both strictly greater than `cfg_thresh`. A difference equal to the threshold, or a sample above the reference, never sets it. `detect` remains 1 until `det_clr`, and a new detection wins over a clear in the same cycle.
- R6: `irq` is 1 exactly while `detect` is 1 and `cfg_int_en` is 1.
- R7: When `cfg_hangup_en` is 1, the cycle after a new detection `hangup_req` pulses for one cycle. `line_in_use` is 1 while `detect` and `cfg_hangup_en` are both 1.
- R8: If `ref_level` is non-zero when the line goes off-hook, the sense value at that moment is kept as the previous sample. It is compared together with the first sample at the end of settling, so an intrusion present at both points is detected at settling end.
- R9: `dial_start` while off-hook opens a window of 0, 1000, 2000 or 4000 ticks for `cfg_block` codes 0, 1, 2 and 3. Samples in the window are discarded and clear the previous-sample history, so two fresh samples are needed after it.
- R10: Going on-hook stops sampling and clears timers and sample history. `ref_level` and `detect` are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| off_hook | input | 1 | Line is off-hook |
| dial_start | input | 1 | Pulse at the start of dialing |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| sense | input | 5 | Loop-current sense value |
| cfg_period | input | 7 | Sample period in 40 ms units |
| cfg_settle | input | 4 | Settling time in 100 ms units |
| cfg_thresh | input | 3 | Differential threshold |
| cfg_force | input | 1 | Freeze the reference level |
| cfg_int_en | input | 1 | Interrupt enable |
| cfg_hangup_en | input | 1 | Hang-up on intrusion enable |
| cfg_block | input | 2 | Dial blocking window code |
| ref_wr | input | 1 | Host write strobe for the reference |
| ref_wr_data | input | 5 | Host reference value |
| det_clr | input | 1 | Host clear of the detect flag |
| ref_level | output | 5 | Current reference level |
| detect | output | 1 | Sticky intrusion flag |
| irq | output | 1 | Masked interrupt |
| hangup_req | output | 1 | One-cycle hang-up request |
| line_in_use | output | 1 | Line taken by a parallel device with hang-up enabled |

## Verification
Several stimulus patterns feed the detector, and each one separates two readings of the rules.

| Pattern | What it tells apart |
|---|---|
| Steady current | One-sample adaptation from two-sample adaptation. |
| Single low sample, then a second one | A one-sample trigger from a two-sample trigger. |
| Drop exactly equal to the threshold | A strict comparison from an inclusive one. |
| Rise above the reference | Signed differences from unsigned ones. |
| Preset reference, current low from the start of settling | A preset that triggers at settling end. |
| Preset reference, current that recovers before settling ends | A preset that must not trigger. |
| Low current inside a dial window, then after it | Samples inside the window are really discarded. |

// File: rtl/lid_pkg.sv
package lid_pkg;
  localparam int SENSE_W = 5;
  localparam int THR_W   = 3;
  localparam int PER_W   = 7;
  localparam int SET_W   = 4;
  localparam int GAP_W   = SENSE_W + 2;

  typedef enum logic [1:0] {PH_IDLE, PH_SETTLE, PH_RUN} phase_t;

  // signed reference minus sample
  function automatic logic signed [GAP_W-1:0] level_gap(
      input logic [SENSE_W-1:0] refv, input logic [SENSE_W-1:0] smp);
    return $signed({2'b00, refv}) - $signed({2'b00, smp});
  endfunction

  function automatic logic gap_over(
      input logic signed [GAP_W-1:0] g, input logic [THR_W-1:0] thr);
    return int'(g) > int'(thr);
  endfunction

  function automatic logic gap_under(
      input logic signed [GAP_W-1:0] g, input logic [THR_W-1:0] thr);
    return int'(g) < int'(thr);
  endfunction

  // blocking window in whole units: 0,1,2,4
  function automatic int unsigned block_units(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 1;
      2'd2:    return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/lid_timer.sv
module lid_timer #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         busy,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (tick && cnt != '0)  cnt <= cnt - W'(1);
  end

  assign busy = (cnt != '0);
  assign done = tick && (cnt == W'(1));
endmodule

// File: rtl/lid_eval.sv
module lid_eval
  import lid_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hist_clr,
  input  logic               early_cap,
  input  logic               samp_evt,
  input  logic               blocked,
  input  logic [SENSE_W-1:0] sense,
  input  logic [THR_W-1:0]   thr,
  input  logic               force_ref,
  input  logic               ref_wr,
  input  logic [SENSE_W-1:0] ref_wr_data,
  input  logic               det_clr,
  output logic [SENSE_W-1:0] ref_level,
  output logic               detect,
  output logic               hit,
  output logic               upd
);
  logic [SENSE_W-1:0]      prev;
  logic                    prev_ok;
  logic signed [GAP_W-1:0] gap_cur, gap_prev;
  logic                    cmp;

  assign gap_cur  = level_gap(ref_level, sense);
  assign gap_prev = level_gap(ref_level, prev);
  assign cmp      = samp_evt && prev_ok && !blocked;
  assign hit      = cmp && gap_over(gap_prev, thr) && gap_over(gap_cur, thr);
  assign upd      = cmp && (sense == prev) && gap_under(gap_cur, thr)
                    && !force_ref && !detect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_level <= '0;
      detect    <= 1'b0;
      prev      <= '0;
      prev_ok   <= 1'b0;
    end else begin
      if (ref_wr)   ref_level <= ref_wr_data;
      else if (upd) ref_level <= sense;

      if (hit)          detect <= 1'b1;
      else if (det_clr) detect <= 1'b0;

      if (hist_clr) begin
        prev_ok <= 1'b0;
      end else if (early_cap) begin
        prev    <= sense;
        prev_ok <= 1'b1;
      end else if (samp_evt) begin
        if (blocked) begin
          prev_ok <= 1'b0;
        end else begin
          prev    <= sense;
          prev_ok <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/line_intrusion_det.sv
module line_intrusion_det
  import lid_pkg::*;
#(
  parameter int SETTLE_MS = 100,
  parameter int SAMPLE_MS = 40,
  parameter int BLOCK_MS  = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               off_hook,
  input  logic               dial_start,
  input  logic               ms_tick,
  input  logic [SENSE_W-1:0] sense,
  input  logic [PER_W-1:0]   cfg_period,
  input  logic [SET_W-1:0]   cfg_settle,
  input  logic [THR_W-1:0]   cfg_thresh,
  input  logic               cfg_force,
  input  logic               cfg_int_en,
  input  logic               cfg_hangup_en,
  input  logic [1:0]         cfg_block,
  input  logic               ref_wr,
  input  logic [SENSE_W-1:0] ref_wr_data,
  input  logic               det_clr,
  output logic [SENSE_W-1:0] ref_level,
  output logic               detect,
  output logic               irq,
  output logic               hangup_req,
  output logic               line_in_use
);
  localparam int SMAX = (2**SET_W - 1) * SETTLE_MS;
  localparam int PMAX = (2**PER_W - 1) * SAMPLE_MS;
  localparam int BMAX = 4 * BLOCK_MS;
  localparam int M1   = (SMAX > PMAX) ? SMAX : PMAX;
  localparam int TMAX = (M1 > BMAX) ? M1 : BMAX;
  localparam int TW   = $clog2(TMAX + 1);

  phase_t       phase;
  logic         idle;
  logic         settle_busy, settle_done;
  logic         samp_busy, samp_done;
  logic         block_busy, block_done;
  logic         samp_evt, early_cap, hit, upd;
  logic [TW-1:0] settle_load, period_load, block_load;

  assign idle = (phase == PH_IDLE);

  assign settle_load = (cfg_settle == '0) ? TW'(1)
                       : TW'(cfg_settle) * TW'(SETTLE_MS);
  assign period_load = (cfg_period == '0) ? TW'(SAMPLE_MS)
                       : TW'(cfg_period) * TW'(SAMPLE_MS);
  assign block_load  = TW'(block_units(cfg_block)) * TW'(BLOCK_MS);

  assign samp_evt  = off_hook &&
                     (((phase == PH_SETTLE) && settle_done) ||
                      ((phase == PH_RUN) && samp_done));
  assign early_cap = idle && off_hook && (ref_level != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE:   if (off_hook) phase <= PH_SETTLE;
        PH_SETTLE: if (!off_hook) phase <= PH_IDLE;
                   else if (settle_done) phase <= PH_RUN;
        default:   if (!off_hook) phase <= PH_IDLE;
      endcase
    end
  end

  lid_timer #(.W(TW)) u_settle (
    .clk(clk), .rst_n(rst_n),
    .load(idle || !off_hook),
    .load_val((idle && off_hook) ? settle_load : '0),
    .tick(ms_tick), .busy(settle_busy), .done(settle_done)
  );

  lid_timer #(.W(TW)) u_sample (
    .clk(clk), .rst_n(rst_n),
    .load(samp_evt || idle || !off_hook),
    .load_val(samp_evt ? period_load : '0),
    .tick(ms_tick), .busy(samp_busy), .done(samp_done)
  );

  lid_timer #(.W(TW)) u_block (
    .clk(clk), .rst_n(rst_n),
    .load(!off_hook || (dial_start && !idle)),
    .load_val(off_hook ? block_load : '0),
    .tick(ms_tick), .busy(block_busy), .done(block_done)
  );

  lid_eval u_eval (
    .clk(clk), .rst_n(rst_n),
    .hist_clr(!off_hook), .early_cap(early_cap), .samp_evt(samp_evt),
    .blocked(block_busy), .sense(sense), .thr(cfg_thresh),
    .force_ref(cfg_force), .ref_wr(ref_wr), .ref_wr_data(ref_wr_data),
    .det_clr(det_clr), .ref_level(ref_level), .detect(detect),
    .hit(hit), .upd(upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hangup_req <= 1'b0;
    else        hangup_req <= hit && !detect && cfg_hangup_en;
  end

  assign irq         = detect && cfg_int_en;
  assign line_in_use = detect && cfg_hangup_en;
endmodule

// File: rtl/lid_checker.sv
module lid_checker
  import lid_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               off_hook,
  input logic               cfg_force,
  input logic               cfg_int_en,
  input logic               ref_wr,
  input logic               det_clr,
  input logic [SENSE_W-1:0] ref_level,
  input logic               detect,
  input logic               irq,
  input logic               hangup_req,
  input logic               samp_evt,
  input logic               blocked,
  input logic               hit
);
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_int_en |-> !irq);

  p_detect_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (detect && !det_clr) |=> detect);

  p_force_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_force && !ref_wr) |=> $stable(ref_level));

  p_frozen_after_detect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (detect && !ref_wr) |=> $stable(ref_level));

  p_block_no_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !hit);

  p_onhook_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !off_hook |-> !samp_evt);

  p_hangup_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hangup_req |-> detect);
endmodule

bind line_intrusion_det lid_checker u_chk (
  .clk(clk), .rst_n(rst_n), .off_hook(off_hook), .cfg_force(cfg_force),
  .cfg_int_en(cfg_int_en), .ref_wr(ref_wr), .det_clr(det_clr),
  .ref_level(ref_level), .detect(detect), .irq(irq),
  .hangup_req(hangup_req), .samp_evt(samp_evt), .blocked(block_busy),
  .hit(hit)
);

// File: tb/line_intrusion_det_tb_top.sv
`timescale 1ns/1ps
module line_intrusion_det_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       off_hook = 0, dial_start = 0, ms_tick = 1;
  logic [4:0] sense = 0;
  logic [6:0] cfg_period = 7'd1;
  logic [3:0] cfg_settle = 4'd1;
  logic [2:0] cfg_thresh = 3'd3;
  logic       cfg_force = 0, cfg_int_en = 1, cfg_hangup_en = 0;
  logic [1:0] cfg_block = 2'd1;
  logic       ref_wr = 0, det_clr = 0;
  logic [4:0] ref_wr_data = 0;
  logic [4:0] ref_level;
  logic       detect, irq, hangup_req, line_in_use;

  int checks = 0, errors = 0, hup_cnt = 0;

  always #2.5 clk = ~clk;

  line_intrusion_det dut_i (
    .clk(clk), .rst_n(rst_n), .off_hook(off_hook), .dial_start(dial_start),
    .ms_tick(ms_tick), .sense(sense), .cfg_period(cfg_period),
    .cfg_settle(cfg_settle), .cfg_thresh(cfg_thresh), .cfg_force(cfg_force),
    .cfg_int_en(cfg_int_en), .cfg_hangup_en(cfg_hangup_en),
    .cfg_block(cfg_block), .ref_wr(ref_wr), .ref_wr_data(ref_wr_data),
    .det_clr(det_clr), .ref_level(ref_level), .detect(detect), .irq(irq),
    .hangup_req(hangup_req), .line_in_use(line_in_use)
  );

  always @(negedge clk) if (hangup_req) hup_cnt++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_clr();
    det_clr = 1; cyc(1); det_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 detect", detect, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ref", ref_level, 0);
    chk("R1 line_in_use", line_in_use, 0);
    chk("R1 hangup", hangup_req, 0);
  endtask

  task automatic t_adapt();
    sense = 20; off_hook = 1;
    cyc(120); chk("R4 one sample no update", ref_level, 0);
    cyc(19);  chk("R2 before second sample", ref_level, 0);
    cyc(2);   chk("R3 adapt on equal pair", ref_level, 20);
  endtask

  task automatic t_intrude();
    sense = 15;
    cyc(60);  chk("R5 one low sample", detect, 0);
    cyc(40);  chk("R5 two low samples", detect, 1);
    chk("R6 irq on detect", irq, 1);
    chk("R7 no hangup when disabled", hup_cnt, 0);
    sense = 19;
    cyc(130); chk("R3 frozen after detect", ref_level, 20);
    pulse_clr();
    chk("R5 clear", detect, 0);
    chk("R6 irq clears", irq, 0);
    cyc(50);  chk("R3 adapt after clear", ref_level, 19);
  endtask

  task automatic t_boundary();
    sense = 16;
    cyc(130); chk("R5 equal threshold no detect", detect, 0);
    chk("R3 equal threshold no update", ref_level, 19);
    sense = 24;
    cyc(90);  chk("R5 above ref no detect", detect, 0);
    chk("R3 signed rise adapts", ref_level, 24);
  endtask

  task automatic t_mask_hangup();
    cfg_int_en = 0; cfg_hangup_en = 1; sense = 10;
    cyc(90);  chk("R6 masked detect", detect, 1);
    chk("R6 masked irq", irq, 0);
    chk("R7 line_in_use", line_in_use, 1);
    chk("R7 one hangup pulse", hup_cnt, 1);
    sense = 24; cyc(45); pulse_clr();
    cfg_int_en = 1; cfg_hangup_en = 0;
    chk("R7 line_in_use off", line_in_use, 0);
  endtask

  task automatic t_block();
    cfg_block = 2'd1;
    dial_start = 1; cyc(1); dial_start = 0; sense = 10;
    cyc(900); chk("R9 blocked", detect, 0);
    cyc(300); chk("R9 after window", detect, 1);
    sense = 24; cyc(45); pulse_clr();
    cfg_block = 2'd0;
    dial_start = 1; cyc(1); dial_start = 0; sense = 10;
    cyc(90);  chk("R9 code zero no window", detect, 1);
    sense = 24; cyc(45); pulse_clr();
  endtask

  task automatic t_force();
    cfg_force = 1; ref_wr_data = 12; ref_wr = 1; cyc(1); ref_wr = 0;
    sense = 14;
    cyc(130); chk("R3 host write kept", ref_level, 12);
    cfg_force = 0;
    cyc(90);  chk("R3 adapt after release", ref_level, 14);
  endtask

  task automatic t_preset();
    off_hook = 0; cyc(5);
    chk("R10 ref kept on-hook", ref_level, 14);
    sense = 5; cfg_settle = 4'd2; off_hook = 1;
    cyc(150); chk("R8 no detect during settle", detect, 0);
    cyc(60);  chk("R8 detect at settle end", detect, 1);
    off_hook = 0; cyc(5);
    chk("R10 detect kept on-hook", detect, 1);
    pulse_clr();
    sense = 5; off_hook = 1;
    cyc(50); sense = 14;
    cyc(200); chk("R8 recovered intrusion ignored", detect, 0);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset();
    t_adapt();
    t_intrude();
    t_boundary();
    t_mask_hangup();
    t_block();
    t_force();
    t_preset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule